// File: doc/BRIEF.md
# Write-Latched Error Status Register

This block gathers error events reported by a local interrupt controller and presents them to software through a status register whose visible contents only change when software writes it. Each cycle, incoming error strobes and checks on sent and received vector numbers set bits in a hidden accumulator. A write to the status register copies the accumulator into the visible register and starts a fresh accumulator. Software therefore writes first and then reads the status of all errors seen since its previous write.

The block also raises an error interrupt through its own local vector entry, which holds a vector number and a mask bit and comes out of reset masked. After one interrupt has been raised, no further interrupt is raised until software writes the status register again, however many more errors arrive. That write rearms the interrupt.

Top module: `err_status_latch`

## Requirements
- R1: After reset, the visible status reads 0x00, the error interrupt is low, the local vector entry is masked (`lvt_mask` = 1) and its vector is 0x00.
- R2: Error bits sit at these positions: 0 send checksum, 1 receive checksum, 2 send accept, 4 receive accept, 5 send illegal vector, 6 receive illegal vector, 7 illegal register address; bit 3 always reads 0.
- R3: A valid sent or received vector below 16 sets bit 5 or bit 6 respectively; a vector of 16 or more, or one whose valid input is low, sets nothing.
- R4: A status write copies all errors gathered since the previous write into the visible status on the clock edge of the write and clears the accumulator; without a write the visible status holds.
- R5: An error arriving in the same cycle as a status write is left out of the value that write exposes and appears after the next write.
- R6: An error arriving while the entry is unmasked and the interrupt is armed raises `err_irq` for exactly the next cycle, with `err_irq_vector` equal to the entry's vector.
- R7: After an interrupt has been raised, further errors raise none until the next status write.
- R8: A status write rearms the interrupt; an error in the same cycle as the write already raises an interrupt in the next cycle.
- R9: While masked, errors raise no interrupt and leave the interrupt armed; unmasking alone raises none for errors seen earlier.
- R10: A write to the local vector entry loads vector and mask on that clock edge; the mask in force during a cycle is the one held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| send_csum_err | input | 1 | Strobe: checksum error on a sent message |
| recv_csum_err | input | 1 | Strobe: checksum error on a received message |
| send_accept_err | input | 1 | Strobe: sent message accepted by no one |
| recv_accept_err | input | 1 | Strobe: received message accepted by no one |
| bad_reg_addr_err | input | 1 | Strobe: access to an unimplemented register |
| send_vec_vld | input | 1 | A vector is being sent this cycle |
| send_vec | input | VEC_W | Vector number being sent |
| recv_vec_vld | input | 1 | A vector is being received this cycle |
| recv_vec | input | VEC_W | Vector number being received |
| esr_wr | input | 1 | Status register write strobe |
| esr_rd_data | output | 8 | Visible error status |
| lvt_wr | input | 1 | Local vector entry write strobe |
| lvt_wr_vector | input | VEC_W | Vector loaded by a local vector entry write |
| lvt_wr_mask | input | 1 | Mask loaded by a local vector entry write |
| lvt_vector | output | VEC_W | Current entry vector |
| lvt_mask | output | 1 | Current entry mask |
| err_irq | output | 1 | One-cycle error interrupt pulse |
| err_irq_vector | output | VEC_W | Vector delivered with the interrupt |

## Verification
Directed patterns try single strobes, bursts of several errors between writes, an error landing on the write cycle, and vectors on both sides of the illegal limit with and without their valid inputs; these separate a correct bit layout and accumulator handover from a lost or misplaced bit and from an off-by-one vector compare. Interrupt patterns string several errors after one interrupt, mask an entry while errors arrive and then unmask it, and write the status while an error arrives, telling single-shot arming from repeated firing and a correct rearm from a lost one. A long random run with sparse strobes, writes and entry updates is compared cycle by cycle against a reference model in the bench.

// File: rtl/esr_pkg.sv
package esr_pkg;
  localparam int unsigned ESR_W = 8;
  localparam int unsigned B_SEND_CSUM = 0;
  localparam int unsigned B_RECV_CSUM = 1;
  localparam int unsigned B_SEND_ACC  = 2;
  localparam int unsigned B_RSVD      = 3;
  localparam int unsigned B_RECV_ACC  = 4;
  localparam int unsigned B_SEND_VEC  = 5;
  localparam int unsigned B_RECV_VEC  = 6;
  localparam int unsigned B_BAD_REG   = 7;
  localparam int unsigned N_VEC_CH    = 2;
  typedef logic [ESR_W-1:0] esr_bits_t;
endpackage

// File: rtl/esr_rst_sync.sv
module esr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/esr_evt_decode.sv
module esr_evt_decode
  import esr_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned ILL_LIMIT = 16
) (
  input  logic                              send_csum_err,
  input  logic                              recv_csum_err,
  input  logic                              send_accept_err,
  input  logic                              recv_accept_err,
  input  logic                              bad_reg_addr_err,
  input  logic [N_VEC_CH-1:0]               vec_vld,
  input  logic [N_VEC_CH-1:0][VEC_W-1:0]    vec_val,
  output esr_bits_t                         evt,
  output logic                              any_evt
);
  localparam logic [VEC_W-1:0] LIMIT = VEC_W'(ILL_LIMIT);

  logic [N_VEC_CH-1:0] vec_bad;

  // one illegal-vector comparator per channel (0 = send, 1 = receive)
  for (genvar ch = 0; ch < N_VEC_CH; ch++) begin : g_vec_chk
    assign vec_bad[ch] = vec_vld[ch] && (vec_val[ch] < LIMIT);
  end

  always_comb begin
    evt              = '0;
    evt[B_SEND_CSUM] = send_csum_err;
    evt[B_RECV_CSUM] = recv_csum_err;
    evt[B_SEND_ACC]  = send_accept_err;
    evt[B_RSVD]      = 1'b0;
    evt[B_RECV_ACC]  = recv_accept_err;
    evt[B_SEND_VEC]  = vec_bad[0];
    evt[B_RECV_VEC]  = vec_bad[1];
    evt[B_BAD_REG]   = bad_reg_addr_err;
  end

  assign any_evt = |evt;
endmodule

// File: rtl/esr_accum.sv
module esr_accum
  import esr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  esr_bits_t evt,
  input  logic      esr_wr,
  output esr_bits_t esr_vis
);
  esr_bits_t acc_q, acc_d;
  esr_bits_t vis_q, vis_d;
  logic      vis_en;

  // next state: the write hands the old accumulator over and
  // same-cycle events seed the new one
  always_comb begin
    vis_en = esr_wr;
    vis_d  = acc_q;
    acc_d  = (esr_wr ? '0 : acc_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vis_q <= '0;
    else if (vis_en) vis_q <= vis_d;
  end

  assign esr_vis = vis_q;
endmodule

// File: rtl/esr_irq_ctl.sv
module esr_irq_ctl #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_evt,
  input  logic             esr_wr,
  input  logic             lvt_wr,
  input  logic [VEC_W-1:0] lvt_wr_vector,
  input  logic             lvt_wr_mask,
  output logic [VEC_W-1:0] lvt_vector,
  output logic             lvt_mask,
  output logic             err_irq,
  output logic [VEC_W-1:0] err_irq_vector
);
  logic [VEC_W-1:0] vec_q;
  logic             mask_q;
  logic             armed_q, armed_d;
  logic             irq_q, fire;

  always_comb begin
    // a write rearms in the same cycle, so an event on that cycle fires
    fire    = any_evt && !mask_q && (armed_q || esr_wr);
    armed_d = armed_q;
    if (esr_wr) armed_d = 1'b1;
    if (fire)   armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
    end else if (lvt_wr) begin
      vec_q  <= lvt_wr_vector;
      mask_q <= lvt_wr_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      irq_q   <= fire;
    end
  end

  assign lvt_vector     = vec_q;
  assign lvt_mask       = mask_q;
  assign err_irq        = irq_q;
  assign err_irq_vector = vec_q;
endmodule

// File: rtl/err_status_latch.sv
module err_status_latch
  import esr_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned ILL_LIMIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send_csum_err,
  input  logic             recv_csum_err,
  input  logic             send_accept_err,
  input  logic             recv_accept_err,
  input  logic             bad_reg_addr_err,
  input  logic             send_vec_vld,
  input  logic [VEC_W-1:0] send_vec,
  input  logic             recv_vec_vld,
  input  logic [VEC_W-1:0] recv_vec,
  input  logic             esr_wr,
  output logic [7:0]       esr_rd_data,
  input  logic             lvt_wr,
  input  logic [VEC_W-1:0] lvt_wr_vector,
  input  logic             lvt_wr_mask,
  output logic [VEC_W-1:0] lvt_vector,
  output logic             lvt_mask,
  output logic             err_irq,
  output logic [VEC_W-1:0] err_irq_vector
);
  logic      rst_n_s;
  esr_bits_t evt;
  logic      any_evt;
  esr_bits_t vis;

  esr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  esr_evt_decode #(.VEC_W(VEC_W), .ILL_LIMIT(ILL_LIMIT)) u_dec (
    .send_csum_err    (send_csum_err),
    .recv_csum_err    (recv_csum_err),
    .send_accept_err  (send_accept_err),
    .recv_accept_err  (recv_accept_err),
    .bad_reg_addr_err (bad_reg_addr_err),
    .vec_vld          ({recv_vec_vld, send_vec_vld}),
    .vec_val          ({recv_vec, send_vec}),
    .evt              (evt),
    .any_evt          (any_evt)
  );

  esr_accum u_acc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .evt     (evt),
    .esr_wr  (esr_wr),
    .esr_vis (vis)
  );

  esr_irq_ctl #(.VEC_W(VEC_W)) u_irq (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .any_evt        (any_evt),
    .esr_wr         (esr_wr),
    .lvt_wr         (lvt_wr),
    .lvt_wr_vector  (lvt_wr_vector),
    .lvt_wr_mask    (lvt_wr_mask),
    .lvt_vector     (lvt_vector),
    .lvt_mask       (lvt_mask),
    .err_irq        (err_irq),
    .err_irq_vector (err_irq_vector)
  );

  assign esr_rd_data = vis;
endmodule

// File: rtl/err_status_latch_chk.sv
module err_status_latch_chk #(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned ILL_LIMIT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             send_csum_err,
  input logic             recv_csum_err,
  input logic             send_accept_err,
  input logic             recv_accept_err,
  input logic             bad_reg_addr_err,
  input logic             send_vec_vld,
  input logic [VEC_W-1:0] send_vec,
  input logic             recv_vec_vld,
  input logic [VEC_W-1:0] recv_vec,
  input logic             esr_wr,
  input logic [7:0]       esr_rd_data,
  input logic             lvt_mask,
  input logic             err_irq
);
  localparam logic [VEC_W-1:0] LIMIT = VEC_W'(ILL_LIMIT);

  logic any_evt;
  logic seen_q;

  assign any_evt = send_csum_err || recv_csum_err || send_accept_err ||
                   recv_accept_err || bad_reg_addr_err ||
                   (send_vec_vld && send_vec < LIMIT) ||
                   (recv_vec_vld && recv_vec < LIMIT);

  // set once an interrupt has been seen since the last status write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (esr_wr)  seen_q <= 1'b0;
    else if (err_irq) seen_q <= 1'b1;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !esr_wr |=> $stable(esr_rd_data));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (esr_wr && !any_evt) ##1 esr_wr |=> (esr_rd_data == 8'h00));

  assert_illvec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (send_vec_vld && send_vec < LIMIT && !esr_wr) ##1 esr_wr |=> esr_rd_data[5]);

  assert_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (any_evt && !lvt_mask && !seen_q && !err_irq && !esr_wr) |=> err_irq);

  assert_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> !seen_q);

  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_evt && !lvt_mask && esr_wr) |=> err_irq);

  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> !$past(lvt_mask));
endmodule

bind err_status_latch err_status_latch_chk #(.VEC_W(VEC_W), .ILL_LIMIT(ILL_LIMIT)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .send_csum_err    (send_csum_err),
  .recv_csum_err    (recv_csum_err),
  .send_accept_err  (send_accept_err),
  .recv_accept_err  (recv_accept_err),
  .bad_reg_addr_err (bad_reg_addr_err),
  .send_vec_vld     (send_vec_vld),
  .send_vec         (send_vec),
  .recv_vec_vld     (recv_vec_vld),
  .recv_vec         (recv_vec),
  .esr_wr           (esr_wr),
  .esr_rd_data      (esr_rd_data),
  .lvt_mask         (lvt_mask),
  .err_irq          (err_irq)
);

// File: tb/err_status_latch_tb_top.sv
`timescale 1ns/1ps
module err_status_latch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] strb = '0;   // {bad_reg, recv_acc, send_acc, recv_csum, send_csum}
  logic sv = 1'b0, rv = 1'b0, wr = 1'b0, lw = 1'b0, lm = 1'b0;
  logic [7:0] svec = '0, rvec = '0, lvec = '0;
  logic [7:0] rd_data, lvt_vec, irq_vec;
  logic lvt_msk, irq;

  int total = 0, bad = 0;
  logic [7:0] m_acc, m_vis, m_vec;
  logic m_mask, m_armed, m_irq;

  always #10 clk = ~clk;

  err_status_latch dut_i (
    .clk(clk), .rst_n(rst_n),
    .send_csum_err(strb[0]), .recv_csum_err(strb[1]),
    .send_accept_err(strb[2]), .recv_accept_err(strb[3]),
    .bad_reg_addr_err(strb[4]),
    .send_vec_vld(sv), .send_vec(svec), .recv_vec_vld(rv), .recv_vec(rvec),
    .esr_wr(wr), .esr_rd_data(rd_data),
    .lvt_wr(lw), .lvt_wr_vector(lvec), .lvt_wr_mask(lm),
    .lvt_vector(lvt_vec), .lvt_mask(lvt_msk),
    .err_irq(irq), .err_irq_vector(irq_vec)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] evt_of(input logic [4:0] s, input logic v0,
      input logic [7:0] x0, input logic v1, input logic [7:0] x1);
    logic [7:0] e;
    e = '0;
    e[0] = s[0]; e[1] = s[1]; e[2] = s[2]; e[4] = s[3]; e[7] = s[4];
    e[5] = v0 && (x0 < 8'd16);
    e[6] = v1 && (x1 < 8'd16);
    return e;
  endfunction

  task automatic step(input logic [4:0] s, input logic v0, input logic [7:0] x0,
      input logic v1, input logic [7:0] x1, input logic w,
      input logic l, input logic [7:0] lv, input logic lmk);
    logic [7:0] e;
    logic fire;
    strb = s; sv = v0; svec = x0; rv = v1; rvec = x1; wr = w;
    lw = l; lvec = lv; lm = lmk;
    @(posedge clk);
    e = evt_of(s, v0, x0, v1, x1);
    fire = (|e) && !m_mask && (m_armed || w);
    m_irq = fire;
    if (w) m_vis = m_acc;
    m_acc = (w ? 8'h00 : m_acc) | e;
    if (w) m_armed = 1'b1;
    if (fire) m_armed = 1'b0;
    if (l) begin m_vec = lv; m_mask = lmk; end
    @(negedge clk);
    chk("R4 model status", rd_data, m_vis);
    chk("R6 model irq", {7'd0, irq}, {7'd0, m_irq});
    if (m_irq) chk("R6 model irq vector", irq_vec, m_vec);
    chk("R10 model mask", {7'd0, lvt_msk}, {7'd0, m_mask});
    chk("R10 model vector", lvt_vec, m_vec);
  endtask

  task automatic idle();
    step(5'b0, 1'b0, 8'h0, 1'b0, 8'h0, 1'b0, 1'b0, 8'h0, 1'b0);
  endtask
  task automatic strobe(input logic [4:0] s);
    step(s, 1'b0, 8'h0, 1'b0, 8'h0, 1'b0, 1'b0, 8'h0, 1'b0);
  endtask
  task automatic wr_esr(input logic [4:0] s);
    step(s, 1'b0, 8'h0, 1'b0, 8'h0, 1'b1, 1'b0, 8'h0, 1'b0);
  endtask
  task automatic set_lvt(input logic [7:0] v, input logic mk);
    step(5'b0, 1'b0, 8'h0, 1'b0, 8'h0, 1'b0, 1'b1, v, mk);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int irq_cnt;
    m_acc = '0; m_vis = '0; m_vec = '0; m_mask = 1'b1; m_armed = 1'b1; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 status", rd_data, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 mask", {7'd0, lvt_msk}, 8'h01);
    chk("R1 vector", lvt_vec, 8'h00);

    set_lvt(8'h3A, 1'b0);
    chk("R10 vector loaded", lvt_vec, 8'h3A);
    chk("R10 unmasked", {7'd0, lvt_msk}, 8'h00);

    strobe(5'b00001);
    chk("R6 irq after error", {7'd0, irq}, 8'h01);
    chk("R6 irq vector", irq_vec, 8'h3A);
    irq_cnt = 0;
    strobe(5'b00010); irq_cnt += irq;
    strobe(5'b01000); irq_cnt += irq;
    idle();           irq_cnt += irq;
    chk("R7 no second irq", irq_cnt[7:0], 8'h00);
    wr_esr(5'b0);
    chk("R2 R4 status bits 0,1,4", rd_data, 8'h13);

    wr_esr(5'b10000);
    chk("R5 same-cycle error excluded", rd_data, 8'h00);
    chk("R8 write-cycle error fires", {7'd0, irq}, 8'h01);
    strobe(5'b00100);
    chk("R7 disarmed after fire", {7'd0, irq}, 8'h00);
    wr_esr(5'b0);
    chk("R5 carried error shown", rd_data, 8'h84);

    step(5'b0, 1'b1, 8'd15, 1'b0, 8'h0, 1'b0, 1'b0, 8'h0, 1'b0);
    chk("R3 vector 15 fires", {7'd0, irq}, 8'h01);
    step(5'b0, 1'b0, 8'h0, 1'b1, 8'd16, 1'b0, 1'b0, 8'h0, 1'b0);
    step(5'b0, 1'b0, 8'h0, 1'b1, 8'd0, 1'b0, 1'b0, 8'h0, 1'b0);
    step(5'b0, 1'b0, 8'd3, 1'b0, 8'd5, 1'b0, 1'b0, 8'h0, 1'b0);
    step(5'b0, 1'b1, 8'd200, 1'b0, 8'h0, 1'b0, 1'b0, 8'h0, 1'b0);
    wr_esr(5'b0);
    chk("R3 illegal vector bits", rd_data, 8'h60);
    chk("R2 bit 3 reserved", {7'd0, rd_data[3]}, 8'h00);
    wr_esr(5'b0);
    chk("R4 accumulator cleared", rd_data, 8'h00);

    set_lvt(8'h3A, 1'b1);
    strobe(5'b00001);
    chk("R9 masked no irq", {7'd0, irq}, 8'h00);
    set_lvt(8'h51, 1'b0);
    idle();
    chk("R9 unmask no late irq", {7'd0, irq}, 8'h00);
    strobe(5'b00010);
    chk("R9 still armed", {7'd0, irq}, 8'h01);
    chk("R10 new vector delivered", irq_vec, 8'h51);
    wr_esr(5'b0);

    void'($urandom(32'h1234));
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] s;
      logic [7:0] x0, x1;
      s = '0;
      for (int b = 0; b < 5; b++) s[b] = ($urandom_range(15) == 0);
      x0 = ($urandom_range(1) == 0) ? 8'($urandom_range(20)) : 8'($urandom);
      x1 = ($urandom_range(1) == 0) ? 8'($urandom_range(20)) : 8'($urandom);
      step(s, $urandom_range(3) == 0, x0, $urandom_range(3) == 0, x1,
           $urandom_range(7) == 0, $urandom_range(31) == 0, 8'($urandom),
           $urandom_range(3) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule